// File: doc/BRIEF.md
# Descriptor Command Sequencer

The block is a four-channel command engine controlled through a small register window. Each channel keeps a pointer to an eight-word descriptor in memory, an 8-bit semaphore count and an error status byte. Software loads the pointer, then adds to the semaphore. While the count is nonzero and the channel is enabled, the engine reads the descriptor one word at a time over a read port. It then passes the descriptor's control words, source, destination, size and payload to an external processing unit through a request/done handshake.

When a descriptor finishes, two control flags decide what follows: one decrements the semaphore, the other raises the channel's completion bit. A nonzero next-descriptor address continues the chain for as long as the semaphore allows. A zero address ends it. A single shared fetch/issue engine serves one channel at a time, and when several channels are ready the lowest-numbered one goes first. A misaligned pointer, a memory read error or a processing-unit error stops the channel, records a code and raises the channel's completion bit.

Top module: `desc_cmd_seq`

## Requirements
- R1: Register map (byte addresses): global completion status at 0x010 (bit n belongs to channel n), its write-ones-to-clear alias at 0x018, channel enable at 0x020 (bit n enables channel n, 8 bits read back). For channel n: pointer at 0x100+0x40*n (reads back the value written), semaphore at 0x110+0x40*n, status at 0x120+0x40*n, status clear at 0x128+0x40*n. Every register reads 0 after reset.
- R2: A write to a semaphore adds the written value to it. The count saturates at 255, and a written value above 255 counts as 255.
- R3: A channel that is enabled, has a pointer written since it last stopped and has a nonzero semaphore reads eight words at pointer+0, +4, ... +28, in that order. Words are ordered: next address, control0, control1, source, destination, size, payload, status.
- R4: If control0 bit 5 (cipher) or bit 6 (hash) is set, the engine raises pu_req_o with the channel number, pu_sel_o = {bit 6, bit 5} and the fetched control0, control1, source, destination, size and payload words. It holds them until pu_done_i. If neither bit is set, the descriptor completes with no handshake.
- R5: On successful completion, control0 bit 1 decrements the semaphore by one and control0 bit 0 sets the channel's global status bit. irq_o is high while any global status bit is set.
- R6: After a successful descriptor, a next address of 0 ends the chain: no further fetch occurs until the pointer is written again. A nonzero next address replaces the pointer. If the semaphore is nonzero, the engine fetches that descriptor, otherwise it waits until the semaphore is raised.
- R7: A channel whose enable bit is 0 never starts, whatever its semaphore holds.
- R8: Only one channel is served at a time. Among ready channels the lowest-numbered one is served first.
- R9: A pointer whose two low bits are not 00 sets status 0x01 without any memory read. It stops the channel and sets its global status bit.
- R10: A read error on the memory port sets status 0x02, stops the channel and sets its global status bit.
- R11: A processing-unit error sets status 0x03, stops the channel and sets its global status bit, with no semaphore decrement. A successful descriptor writes status 0. Writing ones to the status clear alias clears those status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr_o | output | 32 | Descriptor word byte address |
| mem_ack_i | input | 1 | Read acknowledge; data or error valid |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Read error, qualified by mem_ack_i |
| pu_req_o | output | 1 | Work request to the processing unit |
| pu_chan_o | output | 2 | Channel owning the request |
| pu_sel_o | output | 2 | Path select {hash, cipher} |
| pu_ctrl0_o | output | 32 | Descriptor control word 0 |
| pu_ctrl1_o | output | 32 | Descriptor control word 1 |
| pu_src_o | output | 32 | Source address |
| pu_dst_o | output | 32 | Destination address |
| pu_size_o | output | 32 | Transfer size |
| pu_payload_o | output | 32 | Payload address |
| pu_done_i | input | 1 | Processing unit finished the request |
| pu_err_i | input | 1 | Processing unit reports an error, qualified by pu_done_i |
| irq_o | output | 1 | Completion interrupt |

## Verification
A wrong semaphore or pointer state appears at the ports as a descriptor fetched at the wrong address or fetched one time too many or too few. This becomes visible on the memory port within one descriptor time, about ten cycles. A wrong completion decision appears in the semaphore, status and global status reads once the descriptor ends. A grant decision that breaks priority or mutual exclusion appears in the order of channel numbers seen on the processing-unit request. The vectors therefore compare fetch address logs, request order and register read-back after each run, instead of probing internal state.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  // descriptor word order
  localparam int W_NEXT = 0;
  localparam int W_C0   = 1;
  localparam int W_C1   = 2;
  localparam int W_SRC  = 3;
  localparam int W_DST  = 4;
  localparam int W_SIZE = 5;
  localparam int W_PAY  = 6;

  // control0 bits
  localparam int C0_IRQ    = 0;
  localparam int C0_DEC    = 1;
  localparam int C0_CIPHER = 5;
  localparam int C0_HASH   = 6;

  localparam logic [7:0] ERR_NONE  = 8'h00;
  localparam logic [7:0] ERR_ALIGN = 8'h01;
  localparam logic [7:0] ERR_MEM   = 8'h02;
  localparam logic [7:0] ERR_PU    = 8'h03;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_ISSUE,
    ENG_POST
  } eng_state_e;
endpackage

// File: rtl/dcs_chan.sv
module dcs_chan
  import dcs_pkg::*;
#(
  parameter int SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ptr_we_i,
  input  logic              sema_we_i,
  input  logic              stclr_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              cpl_i,
  input  logic [7:0]        cpl_code_i,
  input  logic              cpl_dec_i,
  input  logic [WORD_W-1:0] cpl_next_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] ptr_o,
  output logic [SEMA_W-1:0] sema_o,
  output logic [7:0]        status_o
);
  localparam logic [SEMA_W-1:0] SMAX = '1;

  logic [WORD_W-1:0] ptr_q;
  logic              loaded_q;
  logic [SEMA_W-1:0] sema_q, addend;
  logic [SEMA_W+1:0] sum;
  logic [7:0]        stat_q;
  logic              dec;
  logic              ok;

  assign ok = cpl_i && (cpl_code_i == ERR_NONE);

  always_comb begin
    addend = '0;
    if (sema_we_i) addend = (|wdata_i[WORD_W-1:SEMA_W]) ? SMAX : wdata_i[SEMA_W-1:0];
    dec = ok && cpl_dec_i && (sema_q != '0);
    sum = {2'b00, sema_q} + {2'b00, addend} - {{(SEMA_W+1){1'b0}}, dec};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      loaded_q <= 1'b0;
      sema_q   <= '0;
      stat_q   <= '0;
    end else begin
      sema_q <= (sum > {2'b00, SMAX}) ? SMAX : sum[SEMA_W-1:0];
      if (cpl_i) begin
        if (!ok || cpl_next_i == '0) loaded_q <= 1'b0;
        else ptr_q <= cpl_next_i;
      end
      if (ptr_we_i) begin
        ptr_q    <= wdata_i;
        loaded_q <= 1'b1;
      end
      if (cpl_i && stclr_we_i) stat_q <= cpl_code_i & ~wdata_i[7:0];
      else if (cpl_i)          stat_q <= cpl_code_i;
      else if (stclr_we_i)     stat_q <= stat_q & ~wdata_i[7:0];
    end
  end

  assign ready_o  = en_i && loaded_q && (sema_q != '0);
  assign ptr_o    = ptr_q;
  assign sema_o   = sema_q;
  assign status_o = stat_q;

  // R2
  sema_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sema_q == SMAX && !cpl_i) |=> sema_q == SMAX);
  // R5
  sema_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && cpl_dec_i && !sema_we_i && sema_q != '0) |=> sema_q == $past(sema_q) - 1'b1);
  // R6
  chain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_i && cpl_next_i == '0 && !ptr_we_i) |=> !ready_o);
endmodule

// File: rtl/dcs_arb.sv
module dcs_arb #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i] && !found) begin
        idx_o = CH_W'(i);
        found = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dcs_engine.sv
module dcs_engine
  import dcs_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [CH_W-1:0]   gidx_i,
  input  logic [WORD_W-1:0] ptr_i,
  output logic              start_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              pu_req_o,
  output logic [CH_W-1:0]   pu_chan_o,
  output logic [1:0]        pu_sel_o,
  output logic [WORD_W-1:0] pu_ctrl0_o,
  output logic [WORD_W-1:0] pu_ctrl1_o,
  output logic [WORD_W-1:0] pu_src_o,
  output logic [WORD_W-1:0] pu_dst_o,
  output logic [WORD_W-1:0] pu_size_o,
  output logic [WORD_W-1:0] pu_payload_o,
  input  logic              pu_done_i,
  input  logic              pu_err_i,
  output logic              cpl_o,
  output logic [CH_W-1:0]   cpl_chan_o,
  output logic [7:0]        cpl_code_o,
  output logic              cpl_dec_o,
  output logic              cpl_irq_o,
  output logic [WORD_W-1:0] cpl_next_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

  eng_state_e        state_q;
  logic [CH_W-1:0]   chan_q;
  logic [WORD_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        code_q;
  logic [WORD_W-1:0] desc_q [DESC_WORDS-1];
  logic              uses_pu;

  assign uses_pu = desc_q[W_C0][C0_HASH] | desc_q[W_C0][C0_CIPHER];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      chan_q  <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      code_q  <= ERR_NONE;
      for (int k = 0; k < DESC_WORDS - 1; k++) desc_q[k] <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (any_i) begin
          chan_q <= gidx_i;
          base_q <= ptr_i;
          idx_q  <= '0;
          if (ptr_i[1:0] != 2'b00) begin
            code_q  <= ERR_ALIGN;
            state_q <= ENG_POST;
          end else begin
            state_q <= ENG_FETCH;
          end
        end
        ENG_FETCH: if (mem_ack_i) begin
          if (mem_err_i) begin
            code_q  <= ERR_MEM;
            state_q <= ENG_POST;
          end else if (idx_q == LAST) begin
            code_q  <= ERR_NONE;
            state_q <= uses_pu ? ENG_ISSUE : ENG_POST;
          end else begin
            desc_q[idx_q] <= mem_rdata_i;
            idx_q         <= idx_q + 1'b1;
          end
        end
        ENG_ISSUE: if (pu_done_i) begin
          code_q  <= pu_err_i ? ERR_PU : ERR_NONE;
          state_q <= ENG_POST;
        end
        ENG_POST: state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

  assign start_o      = (state_q == ENG_IDLE) && any_i;
  assign mem_req_o    = (state_q == ENG_FETCH);
  assign mem_addr_o   = base_q + WORD_W'({idx_q, 2'b00});
  assign pu_req_o     = (state_q == ENG_ISSUE);
  assign pu_chan_o    = chan_q;
  assign pu_sel_o     = {desc_q[W_C0][C0_HASH], desc_q[W_C0][C0_CIPHER]};
  assign pu_ctrl0_o   = desc_q[W_C0];
  assign pu_ctrl1_o   = desc_q[W_C1];
  assign pu_src_o     = desc_q[W_SRC];
  assign pu_dst_o     = desc_q[W_DST];
  assign pu_size_o    = desc_q[W_SIZE];
  assign pu_payload_o = desc_q[W_PAY];
  assign cpl_o        = (state_q == ENG_POST);
  assign cpl_chan_o   = chan_q;
  assign cpl_code_o   = code_q;
  assign cpl_dec_o    = desc_q[W_C0][C0_DEC];
  assign cpl_irq_o    = desc_q[W_C0][C0_IRQ];
  assign cpl_next_o   = desc_q[W_NEXT];

  // R3
  mem_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o));
  // R4
  pu_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_req_o && !pu_done_i) |=> pu_req_o && $stable(pu_chan_o) && $stable(pu_ctrl0_o));
  // R8
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, pu_req_o, cpl_o}));
endmodule

// File: rtl/desc_cmd_seq.sv
module desc_cmd_seq
  import dcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int SEMA_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              pu_req_o,
  output logic [CH_W-1:0]   pu_chan_o,
  output logic [1:0]        pu_sel_o,
  output logic [WORD_W-1:0] pu_ctrl0_o,
  output logic [WORD_W-1:0] pu_ctrl1_o,
  output logic [WORD_W-1:0] pu_src_o,
  output logic [WORD_W-1:0] pu_dst_o,
  output logic [WORD_W-1:0] pu_size_o,
  output logic [WORD_W-1:0] pu_payload_o,
  input  logic              pu_done_i,
  input  logic              pu_err_i,
  output logic              irq_o
);
  localparam int EN_W      = 8;
  localparam int A_GSTAT   = 'h010;
  localparam int A_GCLR    = 'h018;
  localparam int A_CHEN    = 'h020;
  localparam int CH_BASE   = 'h100;
  localparam int CH_STRIDE = 'h40;
  localparam int O_PTR     = 'h00;
  localparam int O_SEMA    = 'h10;
  localparam int O_STAT    = 'h20;
  localparam int O_STCLR   = 'h28;

  logic [EN_W-1:0]   en_q;
  logic [NUM_CH-1:0] irq_q, irq_d;
  logic [NUM_CH-1:0] ready;
  logic [WORD_W-1:0] ptr_a  [NUM_CH];
  logic [SEMA_W-1:0] sema_a [NUM_CH];
  logic [7:0]        stat_a [NUM_CH];

  logic              any, start;
  logic [CH_W-1:0]   gidx;
  logic              cpl, cpl_dec, cpl_irq;
  logic [CH_W-1:0]   cpl_chan;
  logic [7:0]        cpl_code;
  logic [WORD_W-1:0] cpl_next;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + i * CH_STRIDE);
    dcs_chan #(.SEMA_W(SEMA_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_q[i]),
      .ptr_we_i   (reg_we_i && reg_addr_i == BASE + ADDR_W'(O_PTR)),
      .sema_we_i  (reg_we_i && reg_addr_i == BASE + ADDR_W'(O_SEMA)),
      .stclr_we_i (reg_we_i && reg_addr_i == BASE + ADDR_W'(O_STCLR)),
      .wdata_i    (reg_wdata_i),
      .cpl_i      (cpl && cpl_chan == CH_W'(i)),
      .cpl_code_i (cpl_code),
      .cpl_dec_i  (cpl_dec),
      .cpl_next_i (cpl_next),
      .ready_o    (ready[i]),
      .ptr_o      (ptr_a[i]),
      .sema_o     (sema_a[i]),
      .status_o   (stat_a[i])
    );
  end

  dcs_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .req_i (ready),
    .any_o (any),
    .idx_o (gidx)
  );

  dcs_engine #(.CH_W(CH_W)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_i        (any),
    .gidx_i       (gidx),
    .ptr_i        (ptr_a[gidx]),
    .start_o      (start),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_err_i    (mem_err_i),
    .pu_req_o     (pu_req_o),
    .pu_chan_o    (pu_chan_o),
    .pu_sel_o     (pu_sel_o),
    .pu_ctrl0_o   (pu_ctrl0_o),
    .pu_ctrl1_o   (pu_ctrl1_o),
    .pu_src_o     (pu_src_o),
    .pu_dst_o     (pu_dst_o),
    .pu_size_o    (pu_size_o),
    .pu_payload_o (pu_payload_o),
    .pu_done_i    (pu_done_i),
    .pu_err_i     (pu_err_i),
    .cpl_o        (cpl),
    .cpl_chan_o   (cpl_chan),
    .cpl_code_o   (cpl_code),
    .cpl_dec_o    (cpl_dec),
    .cpl_irq_o    (cpl_irq),
    .cpl_next_o   (cpl_next)
  );

  always_comb begin
    irq_d = irq_q;
    if (reg_we_i && reg_addr_i == ADDR_W'(A_GCLR)) irq_d = irq_d & ~reg_wdata_i[NUM_CH-1:0];
    if (cpl && (cpl_code != ERR_NONE || cpl_irq)) irq_d[cpl_chan] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (reg_we_i && reg_addr_i == ADDR_W'(A_CHEN)) en_q <= reg_wdata_i[EN_W-1:0];
    end
  end

  assign irq_o = |irq_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_GSTAT)) reg_rdata_o = WORD_W'(irq_q);
    if (reg_addr_i == ADDR_W'(A_CHEN))  reg_rdata_o = WORD_W'(en_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr_i == ADDR_W'(CH_BASE + i * CH_STRIDE + O_PTR))  reg_rdata_o = ptr_a[i];
      if (reg_addr_i == ADDR_W'(CH_BASE + i * CH_STRIDE + O_SEMA)) reg_rdata_o = WORD_W'(sema_a[i]);
      if (reg_addr_i == ADDR_W'(CH_BASE + i * CH_STRIDE + O_STAT)) reg_rdata_o = WORD_W'(stat_a[i]);
    end
  end

  // R7
  start_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> en_q[gidx]);
  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_addr_i == ADDR_W'(A_GCLR))) |=> irq_o);
endmodule

// File: tb/sim_desc_cmd_seq.sv
module sim_desc_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        pu_req, pu_done, pu_err;
  logic [1:0]  pu_chan, pu_sel;
  logic [31:0] pu_c0, pu_c1, pu_src, pu_dst, pu_size, pu_pay;
  logic        irq;

  always #5 clk = ~clk;

  desc_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .pu_req_o(pu_req), .pu_chan_o(pu_chan), .pu_sel_o(pu_sel),
    .pu_ctrl0_o(pu_c0), .pu_ctrl1_o(pu_c1), .pu_src_o(pu_src), .pu_dst_o(pu_dst),
    .pu_size_o(pu_size), .pu_payload_o(pu_pay), .pu_done_i(pu_done),
    .pu_err_i(pu_err), .irq_o(irq)
  );

  // memory model: one-cycle ack, errors above 0x3FF
  logic [31:0] mem [256];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_err   = mem_req && (mem_addr[31:10] != '0);

  // processing unit model: done on third request cycle, error on payload 0xBAD
  int          lat, pu_n, fetch_n;
  logic [31:0] flog [64];
  logic [1:0]  olog [16];
  logic [31:0] l_c0, l_c1, l_src, l_dst, l_size, l_pay;
  logic [1:0]  l_chan, l_sel;
  assign pu_done = pu_req && (lat == 2);
  assign pu_err  = pu_pay == 32'h0000_0BAD;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 0; pu_n <= 0; fetch_n <= 0;
    end else begin
      if (mem_req && mem_ack) begin
        flog[fetch_n % 64] <= mem_addr;
        fetch_n <= fetch_n + 1;
      end
      if (pu_req) begin
        if (pu_done) begin
          lat <= 0;
          olog[pu_n % 16] <= pu_chan;
          pu_n <= pu_n + 1;
          l_c0 <= pu_c0; l_c1 <= pu_c1; l_src <= pu_src; l_dst <= pu_dst;
          l_size <= pu_size; l_pay <= pu_pay; l_chan <= pu_chan; l_sel <= pu_sel;
        end else lat <= lat + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, c0, c1, src, dst, sz, pay);
    mem[(base >> 2) + 0] = nxt;  mem[(base >> 2) + 1] = c0;
    mem[(base >> 2) + 2] = c1;   mem[(base >> 2) + 3] = src;
    mem[(base >> 2) + 4] = dst;  mem[(base >> 2) + 5] = sz;
    mem[(base >> 2) + 6] = pay;  mem[(base >> 2) + 7] = 32'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] ca(input int ch, input int off);
    return 12'(32'h100 + ch * 32'h40 + off);
  endfunction

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] c0, c1, src, dst, size, pay;
    logic [7:0]  sema;
    logic        irq;
    logic        pu;
  } vec_t;

  localparam vec_t VT [4] = '{
    '{2'd0, 32'h23, 32'h10,    32'h1000, 32'h2000, 32'h40, 32'h3000, 8'd0, 1'b1, 1'b1},
    '{2'd1, 32'h40, 32'h20000, 32'h1100, 32'h0,    32'h80, 32'h0,    8'd1, 1'b0, 1'b1},
    '{2'd2, 32'h63, 32'h20010, 32'h1200, 32'h2200, 32'h10, 32'h3300, 8'd0, 1'b1, 1'b1},
    '{2'd3, 32'h01, 32'h0,     32'h1300, 32'h2300, 32'h20, 32'h0,    8'd1, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p0, f0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    do_reset();

    // R1 reset values
    rd(12'h010, d); chk("R1", "gstat after reset", d, 0);
    rd(12'h020, d); chk("R1", "enable after reset", d, 0);
    rd(ca(0, 'h10), d); chk("R1", "sema0 after reset", d, 0);
    rd(ca(2, 'h20), d); chk("R1", "status2 after reset", d, 0);
    chk("R1", "irq after reset", 32'(irq), 0);

    // vector table: R4 R5 handoff and completion flags
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(12'h020, 32'hFF);
      put_desc(32'h40 * (i + 1), 0, VT[i].c0, VT[i].c1, VT[i].src, VT[i].dst, VT[i].size, VT[i].pay);
      wr(ca(VT[i].ch, 0), 32'h40 * (i + 1));
      p0 = pu_n;
      wr(ca(VT[i].ch, 'h10), 1);
      idle(40);
      chk("R4", "handshake count", 32'(pu_n - p0), 32'(VT[i].pu));
      if (VT[i].pu) begin
        chk("R4", "ctrl0", l_c0, VT[i].c0);
        chk("R4", "ctrl1", l_c1, VT[i].c1);
        chk("R4", "src/dst", l_src ^ {l_dst[15:0], l_dst[31:16]}, VT[i].src ^ {VT[i].dst[15:0], VT[i].dst[31:16]});
        chk("R4", "size", l_size, VT[i].size);
        chk("R4", "payload", l_pay, VT[i].pay);
        chk("R4", "chan", 32'(l_chan), 32'(VT[i].ch));
        chk("R4", "sel", 32'(l_sel), 32'(VT[i].c0[6:5]));
      end
      rd(ca(VT[i].ch, 'h10), d); chk("R5", "sema after run", d, 32'(VT[i].sema));
      rd(12'h010, d); chk("R5", "gstat bit", 32'(d[VT[i].ch]), 32'(VT[i].irq));
      chk("R5", "irq_o", 32'(irq), 32'(VT[i].irq));
      rd(ca(VT[i].ch, 'h20), d); chk("R11", "status on success", d, 0);
    end

    // R2 semaphore add and saturation (channel disabled)
    do_reset();
    wr(ca(0, 'h10), 3); wr(ca(0, 'h10), 5);
    rd(ca(0, 'h10), d); chk("R2", "sema 3+5", d, 8);
    wr(ca(0, 'h10), 250);
    rd(ca(0, 'h10), d); chk("R2", "sema saturate", d, 255);
    wr(ca(1, 'h10), 32'h1000);
    rd(ca(1, 'h10), d); chk("R2", "large add saturates", d, 255);

    // R7 disabled channel, then R3 fetch order
    do_reset();
    wr(12'h020, 32'hF7);
    put_desc(32'h40, 0, 32'h03, 0, 0, 0, 0, 0);
    wr(ca(3, 0), 32'h40);
    wr(ca(3, 'h10), 1);
    idle(40);
    chk("R7", "no fetch while disabled", 32'(fetch_n), 0);
    rd(ca(3, 'h10), d); chk("R7", "sema kept while disabled", d, 1);
    wr(12'h020, 32'hFF);
    idle(40);
    chk("R7", "fetch after enable", 32'(fetch_n), 8);
    begin
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < 8; k++) if (flog[k] !== 32'h40 + 4 * k) ok = 1'b0;
      chk("R3", "fetch address order", 32'(ok), 1);
    end
    rd(ca(3, 'h10), d); chk("R5", "sema decremented", d, 0);
    rd(12'h010, d); chk("R5", "gstat ch3", d, 32'h8);

    // R6 chaining
    do_reset();
    wr(12'h020, 32'hFF);
    put_desc(32'h100, 32'h140, 32'h03, 0, 0, 0, 0, 0);
    put_desc(32'h140, 0, 32'h03, 0, 0, 0, 0, 0);
    wr(ca(0, 0), 32'h100);
    wr(ca(0, 'h10), 2);
    idle(60);
    chk("R6", "two linked descriptors fetched", 32'(fetch_n), 16);
    rd(ca(0, 0), d); chk("R6", "pointer follows link", d, 32'h140);
    put_desc(32'h180, 32'h1C0, 32'h03, 0, 0, 0, 0, 0);
    put_desc(32'h1C0, 0, 32'h03, 0, 0, 0, 0, 0);
    wr(ca(0, 0), 32'h180);
    wr(ca(0, 'h10), 1);
    idle(40);
    chk("R6", "stop when sema exhausted", 32'(fetch_n), 24);
    rd(ca(0, 0), d); chk("R6", "pointer holds next", d, 32'h1C0);
    wr(ca(0, 'h10), 1);
    idle(40);
    chk("R6", "resume on sema", 32'(fetch_n), 32);
    wr(ca(0, 'h10), 1);
    idle(40);
    chk("R6", "chain ended, no fetch", 32'(fetch_n), 32);
    rd(ca(0, 'h10), d); chk("R6", "sema untouched after end", d, 1);

    // R8 fixed priority
    do_reset();
    put_desc(32'h40, 0, 32'h23, 0, 0, 0, 0, 0);
    put_desc(32'h80, 0, 32'h23, 0, 0, 0, 0, 0);
    put_desc(32'hC0, 0, 32'h23, 0, 0, 0, 0, 0);
    wr(ca(2, 0), 32'h40); wr(ca(1, 0), 32'h80); wr(ca(3, 0), 32'hC0);
    wr(ca(3, 'h10), 1); wr(ca(2, 'h10), 1); wr(ca(1, 'h10), 1);
    wr(12'h020, 32'hFF);
    idle(80);
    chk("R8", "three requests", 32'(pu_n), 3);
    chk("R8", "grant order", {26'b0, olog[0], olog[1], olog[2]}, {26'b0, 2'd1, 2'd2, 2'd3});

    // R9 misaligned pointer
    do_reset();
    wr(12'h020, 32'hFF);
    wr(ca(1, 0), 32'h42);
    wr(ca(1, 'h10), 1);
    idle(20);
    rd(ca(1, 'h20), d); chk("R9", "align status", d, 32'h01);
    chk("R9", "no memory read", 32'(fetch_n), 0);
    rd(12'h010, d); chk("R9", "gstat bit1", d, 32'h2);
    chk("R9", "irq_o", 32'(irq), 1);
    wr(ca(1, 'h10), 1);
    idle(20);
    chk("R9", "channel stopped", 32'(fetch_n), 0);
    wr(ca(1, 'h28), 32'hFFFF_FFFF);
    rd(ca(1, 'h20), d); chk("R11", "status cleared", d, 0);
    wr(12'h018, 32'h2);
    rd(12'h010, d); chk("R5", "gstat cleared", d, 0);
    chk("R5", "irq_o cleared", 32'(irq), 0);

    // R10 memory error
    wr(ca(2, 0), 32'h800);
    wr(ca(2, 'h10), 1);
    idle(20);
    rd(ca(2, 'h20), d); chk("R10", "mem error status", d, 32'h02);
    rd(12'h010, d); chk("R10", "gstat bit2", d, 32'h4);

    // R11 processing-unit error
    do_reset();
    wr(12'h020, 32'hFF);
    put_desc(32'h40, 0, 32'h22, 0, 0, 0, 0, 32'hBAD);
    wr(ca(0, 0), 32'h40);
    wr(ca(0, 'h10), 1);
    idle(40);
    rd(ca(0, 'h20), d); chk("R11", "pu error status", d, 32'h03);
    rd(12'h010, d); chk("R11", "gstat bit0 without irq flag", d, 32'h1);
    rd(ca(0, 'h10), d); chk("R11", "no decrement on error", d, 1);
    f0 = fetch_n;
    wr(ca(0, 'h10), 1);
    idle(30);
    chk("R11", "stopped after error", 32'(fetch_n), 32'(f0));

    // R1 readback
    wr(ca(3, 0), 32'hDEAD_BEE0);
    rd(ca(3, 0), d); chk("R1", "pointer readback", d, 32'hDEAD_BEE0);
    rd(12'h020, d); chk("R1", "enable readback", d, 32'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule